// File: doc/BRIEF.md
# Read/Write Bus Turnaround Controller

This block decides which direction a shared memory data bus serves. It watches how many requests wait in the read queue and in the write queue, and it counts the bursts that are issued in the current direction. From these it selects a bus mode and grants one queue at a time. Writes are held back until the write queue is nearly full. They are then drained in a batch until the queue falls to a low watermark. Every change of direction costs a fixed number of dead cycles, so the bus does not turn around too often.

The scheduler that picks a request inside a queue uses the grants to decide whether it may issue a read or a write. It sends back a one-cycle pulse, tagged read or write, for each burst it puts on the bus. Thresholds, the minimum write batch and both turnaround delays are parameters.

Top module: `bus_turn_ctrl`

## Requirements
- R1: After reset the mode is READ (code 0), `grant_rd` is 1, `grant_wr` is 0 and the write counter is cleared.
- R2: In READ, a write occupancy at or above `WR_HI` moves the mode to READ_TO_WRITE (code 1) on the next edge, even if reads are pending. Below `WR_HI`, with reads pending, the mode stays READ.
- R3: In READ, an empty read queue together with a non-empty write queue starts a turnaround even below `WR_HI`. When both queues are empty the mode stays READ.
- R4: READ_TO_WRITE lasts exactly `T_RTW`+1 cycles with neither grant asserted. The mode then becomes WRITE (code 2).
- R5: WRITE_TO_READ (code 3) lasts exactly `T_WTR`+1 cycles with neither grant asserted. The mode then becomes READ. Queue levels seen during a transition have no effect on it.
- R6: WRITE is left for WRITE_TO_READ only once at least `MIN_WR` write bursts have been issued in this WRITE phase and the write occupancy is at or below `WR_LO`. While the occupancy is above `WR_LO`, or fewer than `MIN_WR` writes have been issued, the mode stays WRITE.
- R7: In WRITE, an empty write queue with reads pending leaves for WRITE_TO_READ whatever the write count is.
- R8: Only pulses with `issue_is_wr`=1 count toward `MIN_WR`, and the count restarts from zero on every turnaround.
- R9: `grant_rd` is 1 exactly in READ and `grant_wr` is 1 exactly in WRITE. The two grants are never 1 together.
- R10: A configuration that breaks `WR_LO < WR_HI <= WRQ_DEPTH` is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_count | input | $clog2(RDQ_DEPTH+1) | Read queue occupancy |
| wr_count | input | $clog2(WRQ_DEPTH+1) | Write queue occupancy |
| issue_vld | input | 1 | One burst issued this cycle |
| issue_is_wr | input | 1 | The issued burst is a write |
| mode | output | 2 | Bus mode: 0 read, 1 read-to-write, 2 write, 3 write-to-read |
| grant_rd | output | 1 | Read queue may issue |
| grant_wr | output | 1 | Write queue may issue |

## Verification
The bench builds the block with `WR_HI`=8, `WR_LO`=2, `MIN_WR`=3, `T_RTW`=2 and `T_WTR`=3, so the two turnaround windows have different lengths and a length error in either one shows up. With a small minimum batch and a low watermark well below the high one, a few cycles are enough to reach both the hysteresis band and the case of a batch below the minimum. A second write phase shows whether the write count was cleared on the turnaround.

// File: rtl/bus_turn_ctrl.sv
module bus_turn_ctrl #(
  parameter int RDQ_DEPTH = 32,
  parameter int WRQ_DEPTH = 32,
  parameter int WR_HI     = 24,
  parameter int WR_LO     = 8,
  parameter int MIN_WR    = 8,
  parameter int T_RTW     = 2,
  parameter int T_WTR     = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [$clog2(RDQ_DEPTH+1)-1:0] rd_count,
  input  logic [$clog2(WRQ_DEPTH+1)-1:0] wr_count,
  input  logic                           issue_vld,
  input  logic                           issue_is_wr,
  output logic [1:0]                     mode,
  output logic                           grant_rd,
  output logic                           grant_wr
);
  localparam int WCW  = $clog2(WRQ_DEPTH+1);
  localparam int CNTW = $clog2(MIN_WR+2);
  localparam int TMAX = (T_RTW > T_WTR) ? T_RTW : T_WTR;
  localparam int TW   = $clog2(TMAX+2);

  typedef enum logic [1:0] {
    M_RD = 2'd0, M_R2W = 2'd1, M_WR = 2'd2, M_W2R = 2'd3
  } mode_e;

  if (!(WR_LO < WR_HI && WR_HI <= WRQ_DEPTH)) begin : g_r10_bad_cfg
    $error("R10: thresholds must satisfy WR_LO < WR_HI <= WRQ_DEPTH");
  end

  mode_e            st, st_nx;
  logic [CNTW-1:0]  dir_cnt;
  logic [TW-1:0]    tmr;
  logic             min_met, rd_pend, wr_pend, turn;

  assign rd_pend  = (rd_count != '0);
  assign wr_pend  = (wr_count != '0);
  assign min_met  = (dir_cnt >= CNTW'(MIN_WR));
  assign mode     = st;
  assign grant_rd = (st == M_RD);
  assign grant_wr = (st == M_WR);
  assign turn     = (st_nx != st);

  always_comb begin
    st_nx = st;
    case (st)
      M_RD:  if (wr_count >= WCW'(WR_HI) || (!rd_pend && wr_pend)) st_nx = M_R2W;
      M_R2W: if (tmr == '0) st_nx = M_WR;
      M_WR:  if ((min_met && wr_count <= WCW'(WR_LO)) || (!wr_pend && rd_pend)) st_nx = M_W2R;
      M_W2R: if (tmr == '0) st_nx = M_RD;
      default: st_nx = M_RD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= M_RD;
      dir_cnt <= '0;
      tmr     <= '0;
    end else begin
      st <= st_nx;
      if (turn) begin
        dir_cnt <= '0;
        tmr     <= (st_nx == M_R2W) ? TW'(T_RTW) : TW'(T_WTR);
      end else begin
        if (tmr != '0) tmr <= tmr - 1'b1;
        if (issue_vld && (issue_is_wr == (st == M_WR)) && !min_met &&
            (st == M_WR || st == M_RD))
          dir_cnt <= dir_cnt + 1'b1;
      end
    end
  end

  a_r2_hi_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && wr_count >= WCW'(WR_HI)) |=> (mode == 2'd1));
  a_r4_r2w_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1) |=> (mode == 2'd1 || mode == 2'd2));
  a_r5_w2r_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3) |=> (mode == 2'd3 || mode == 2'd0));
  a_r4_wr_grant_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_wr) |-> ($past(mode) == 2'd1));
  a_r5_rd_grant_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_rd) |-> ($past(mode) == 2'd3));
  a_r6_hysteresis: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && wr_count > WCW'(WR_LO)) |=> (mode == 2'd2));
  a_r9_grant_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({grant_rd, grant_wr}));
endmodule

// File: tb/bus_turn_ctrl_bench.sv
module bus_turn_ctrl_bench;
  localparam int RDQ = 16, WRQ = 16, HI = 8, LO = 2, MINW = 3, RTW = 2, WTR = 3;
  localparam int RCW = $clog2(RDQ+1), WCW = $clog2(WRQ+1);

  logic clk = 0, rst_n = 0;
  logic [RCW-1:0] rd_count = '0;
  logic [WCW-1:0] wr_count = '0;
  logic issue_vld = 0, issue_is_wr = 0;
  logic [1:0] mode;
  logic grant_rd, grant_wr;

  always #5 clk = ~clk;

  bus_turn_ctrl #(.RDQ_DEPTH(RDQ), .WRQ_DEPTH(WRQ), .WR_HI(HI), .WR_LO(LO),
    .MIN_WR(MINW), .T_RTW(RTW), .T_WTR(WTR)) u_bus_turn_ctrl (
    .clk(clk), .rst_n(rst_n), .rd_count(rd_count), .wr_count(wr_count),
    .issue_vld(issue_vld), .issue_is_wr(issue_is_wr),
    .mode(mode), .grant_rd(grant_rd), .grant_wr(grant_wr));

  typedef struct { logic [1:0] m; string req; } exp_t;
  exp_t sb[$];
  int checks = 0, errors = 0;
  bit done = 0;

  // Drive inputs for one cycle; expect the mode after the next edge.
  task automatic step(int rd, int wr, bit iv, bit iw, logic [1:0] m, string req);
    exp_t e;
    @(negedge clk);
    rd_count = RCW'(rd); wr_count = WCW'(wr); issue_vld = iv; issue_is_wr = iw;
    @(posedge clk);
    #1;
    e.m = m; e.req = req;
    sb.push_back(e);
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (mode !== e.m || grant_rd !== (e.m == 2'd0) || grant_wr !== (e.m == 2'd2)) begin
        errors++;
        $display("FAIL %s: mode=%0d rd=%b wr=%b expected mode=%0d rd=%b wr=%b",
                 e.req, mode, grant_rd, grant_wr, e.m, e.m == 2'd0, e.m == 2'd2);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    step(0, 0, 0, 0, 2'd0, "R1");
    rst_n = 1;
    step(0, 0, 0, 0, 2'd0, "R1");
    step(0, 0, 0, 0, 2'd0, "R3_both_empty");
    step(5, 7, 1, 0, 2'd0, "R2_below_hi");
    step(5, 7, 0, 0, 2'd0, "R2_below_hi");
    // high watermark -> R2W for RTW+1 cycles then WRITE
    step(5, 8, 0, 0, 2'd1, "R2_hi");
    step(5, 8, 0, 0, 2'd1, "R4");
    step(5, 0, 0, 0, 2'd1, "R4_ignore_levels");
    step(5, 8, 0, 0, 2'd2, "R4_to_write");
    // write batch: count below minimum holds WRITE
    step(5, 7, 1, 1, 2'd2, "R6");
    step(5, 2, 1, 1, 2'd2, "R6_min_not_met");
    step(5, 2, 1, 0, 2'd2, "R8_read_issue_ignored");
    step(5, 2, 0, 0, 2'd2, "R8_read_issue_ignored");
    step(5, 5, 1, 1, 2'd2, "R6");
    step(5, 5, 0, 0, 2'd2, "R6_hysteresis");
    step(5, 2, 0, 0, 2'd3, "R6_exit_low");
    step(5, 12, 0, 0, 2'd3, "R5");
    step(5, 12, 0, 0, 2'd3, "R5_ignore_levels");
    step(5, 12, 0, 0, 2'd3, "R5");
    step(5, 3, 0, 0, 2'd0, "R5_to_read");
    // empty read queue, one write waiting
    step(0, 1, 0, 0, 2'd1, "R3_empty_reads");
    step(0, 1, 0, 0, 2'd1, "R4");
    step(0, 1, 0, 0, 2'd1, "R4");
    step(0, 1, 0, 0, 2'd2, "R4");
    step(4, 0, 0, 0, 2'd3, "R7_empty_writes");
    step(4, 0, 0, 0, 2'd3, "R5");
    step(4, 0, 0, 0, 2'd3, "R5");
    step(4, 0, 0, 0, 2'd3, "R5");
    step(4, 0, 0, 0, 2'd0, "R5");
    // second write phase: count must restart from zero
    step(4, 9, 0, 0, 2'd1, "R2_hi");
    step(4, 9, 0, 0, 2'd1, "R4");
    step(4, 9, 0, 0, 2'd1, "R4");
    step(4, 2, 0, 0, 2'd2, "R4");
    step(4, 2, 0, 0, 2'd2, "R8_count_cleared");
    step(4, 2, 1, 1, 2'd2, "R8");
    step(4, 2, 1, 1, 2'd2, "R8");
    step(4, 2, 1, 1, 2'd2, "R8");
    step(4, 2, 0, 0, 2'd3, "R6_exit_low");
    step(4, 2, 0, 0, 2'd3, "R9");
    @(negedge clk);
    @(negedge clk);
    done = 1;
  end

  initial begin
    int cyc;
    for (cyc = 0; cyc < 5000 && !done; cyc++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule